// File: doc/BRIEF.md
# Serial Transceiver with Doze and Stop Gating

This block is an asynchronous serial transmitter and receiver with a one-entry transmit holding register and a one-entry receive buffer. Each character is a low start bit, eight data bits sent least significant bit first, and a high stop bit. A programmable divisor sets the speed. Software writes characters and settings through a small register port and reads received data and status back through the same port.

Two low-power requests gate the block's internal clock. The clock gate is modelled as a synchronous enable. The doze request takes effect only when the doze enable bit is set. The block then completes any character that is already on the line in either direction, starts no new one, and halts until the request is withdrawn. The stop request freezes every state element in the cycle it is asserted, including the line output, and a later release resumes from exactly that point. A `quiescent` output reports that the block is halted.

Top module: `uart_lp`

## Requirements
- R1: After reset, `txd` is high, `quiescent` is low, the status register (address 3) reads 0, the control register (address 2) reads 0 and the divisor register (address 1) reads 3.
- R2: A byte written to address 0 is sent on `txd` as one low start bit, eight data bits least significant bit first and one high stop bit, each bit lasting 16 × (divisor + 1) clock cycles.
- R3: A frame received on `rxd` with a high stop bit sets status bit 1 and makes the byte readable at address 0. A read of address 0 with `rd_en` high clears status bit 1. A frame whose stop bit is low leaves status bit 1 clear.
- R4: The transmit path holds at most one waiting byte. A write to address 0 while that entry is full is dropped. Status bit 0 is high while a character is being sent or a byte is waiting.
- R5: With control bit 0 set, a doze request lets the character in flight finish, starts no new character, and then halts the block with `txd` high.
- R6: When the doze request is withdrawn, the block continues from its halted state with no reset, and a byte written during the halt is then transmitted.
- R7: With control bit 0 clear, the doze request has no effect: `quiescent` stays low and characters keep flowing.
- R8: While `stop_req` is high, all state, including `txd`, the frame engines and the registers, holds the value it had when the request arrived. Register writes are ignored during this time.
- R9: After `stop_req` falls, a character that was interrupted mid-frame completes with correct content on both the transmit and receive sides.
- R10: `quiescent` is high exactly while the block is halted by stop or by an accepted doze request, and no frame state changes while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 data, 1 divisor, 2 control, 3 status |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; a read of address 0 clears the receive-valid flag |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles high |
| doze_req | input | 1 | Doze request, honoured when control bit 0 is set |
| stop_req | input | 1 | Stop request, freezes in the same cycle |
| quiescent | output | 1 | Block halted by doze or stop |

## Verification
On every cycle, the assertions check that a stop request leaves the frame engines, the line output and the registers unchanged on the next edge. They also check that an accepted doze halt occurs only with both engines idle, that the frame state is frozen while `quiescent` is high, and that `quiescent` cannot rise from doze while the enable bit is clear. The bench scenarios are needed to show that frames have the right bit order and bit length. They also show that a character cut off by stop or held back by doze later arrives intact, that a dropped second write never appears on the line, and that a bad stop bit leaves no data behind.

// File: rtl/uart_lp_pkg.sv
package uart_lp_pkg;

    localparam int CHAR_W = 8;
    localparam int OVS    = 16;
    localparam int PH_W   = $clog2(OVS);
    localparam int IDX_W  = $clog2(CHAR_W);

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_DATA  = 2'd2,
        FR_STOP  = 2'd3
    } frame_st_t;

    typedef struct packed {
        frame_st_t          st;
        logic [PH_W-1:0]    ph;
        logic [IDX_W-1:0]   idx;
        logic [CHAR_W-1:0]  sh;
    } frame_ctx_t;

    localparam frame_ctx_t CTX_IDLE = '{st: FR_IDLE, ph: '0, idx: '0, sh: '0};

    function automatic logic ph_last(input logic [PH_W-1:0] ph);
        return ph == PH_W'(OVS - 1);
    endfunction

    function automatic logic ph_mid(input logic [PH_W-1:0] ph);
        return ph == PH_W'(OVS / 2 - 1);
    endfunction

    function automatic logic idx_last(input logic [IDX_W-1:0] idx);
        return idx == IDX_W'(CHAR_W - 1);
    endfunction

    function automatic logic [2:0] pack_status(input logic busy, input logic valid,
                                               input logic quiet);
        return {quiet, valid, busy};
    endfunction

endpackage

// File: rtl/uart_lp_baud.sv
module uart_lp_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = cnt >= div;
    assign tick = en && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_lp_tx.sv
module uart_lp_tx
    import uart_lp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    output logic              txd,
    output logic              idle,
    output frame_ctx_t        ctx_o
);
    frame_ctx_t ctx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= CTX_IDLE;
            txd <= 1'b1;
        end else if (en) begin
            if (ctx.st == FR_IDLE) begin
                if (load) begin
                    ctx.st <= FR_START;
                    ctx.ph <= '0;
                    ctx.sh <= load_data;
                    txd    <= 1'b0;
                end
            end else if (tick) begin
                ctx.ph <= ctx.ph + 1'b1;
                if (ph_last(ctx.ph)) begin
                    case (ctx.st)
                        FR_START: begin
                            ctx.st  <= FR_DATA;
                            ctx.idx <= '0;
                            txd     <= ctx.sh[0];
                            ctx.sh  <= ctx.sh >> 1;
                        end
                        FR_DATA: begin
                            if (idx_last(ctx.idx)) begin
                                ctx.st <= FR_STOP;
                                txd    <= 1'b1;
                            end else begin
                                ctx.idx <= ctx.idx + 1'b1;
                                txd     <= ctx.sh[0];
                                ctx.sh  <= ctx.sh >> 1;
                            end
                        end
                        default: ctx.st <= FR_IDLE;
                    endcase
                end
            end
        end
    end

    assign idle  = ctx.st == FR_IDLE;
    assign ctx_o = ctx;
endmodule

// File: rtl/uart_lp_rx.sv
module uart_lp_rx
    import uart_lp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              allow_start,
    input  logic              rxd,
    output logic              done,
    output logic [CHAR_W-1:0] byte_o,
    output logic              idle,
    output frame_ctx_t        ctx_o
);
    frame_ctx_t ctx;
    logic [1:0] sync;
    logic       rxs;

    assign rxs = sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= 2'b11;
        end else if (en) begin
            sync <= {sync[0], rxd};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= CTX_IDLE;
        end else if (en && tick) begin
            case (ctx.st)
                FR_IDLE: begin
                    if (allow_start && !rxs) begin
                        ctx.st <= FR_START;
                        ctx.ph <= '0;
                    end
                end
                FR_START: begin
                    ctx.ph <= ctx.ph + 1'b1;
                    if (ph_mid(ctx.ph)) begin
                        if (!rxs) begin
                            ctx.st  <= FR_DATA;
                            ctx.ph  <= '0;
                            ctx.idx <= '0;
                        end else begin
                            ctx.st <= FR_IDLE;
                        end
                    end
                end
                FR_DATA: begin
                    ctx.ph <= ctx.ph + 1'b1;
                    if (ph_last(ctx.ph)) begin
                        ctx.sh <= {rxs, ctx.sh[CHAR_W-1:1]};
                        if (idx_last(ctx.idx)) begin
                            ctx.st <= FR_STOP;
                        end else begin
                            ctx.idx <= ctx.idx + 1'b1;
                        end
                    end
                end
                default: begin
                    ctx.ph <= ctx.ph + 1'b1;
                    if (ph_last(ctx.ph)) begin
                        ctx.st <= FR_IDLE;
                    end
                end
            endcase
        end
    end

    assign done   = en && tick && (ctx.st == FR_STOP) && ph_last(ctx.ph) && rxs;
    assign byte_o = ctx.sh;
    assign idle   = ctx.st == FR_IDLE;
    assign ctx_o  = ctx;
endmodule

// File: rtl/uart_lp.sv
module uart_lp
    import uart_lp_pkg::*;
#(
    parameter int              REG_W    = 8,
    parameter logic [REG_W-1:0] DIV_INIT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             rxd,
    output logic             txd,
    input  logic             doze_req,
    input  logic             stop_req,
    output logic             quiescent
);
    logic              doze_en;
    logic              doze_pend;
    logic              doze_halt;
    logic              clk_en;
    logic [REG_W-1:0]  div_q;
    logic              tick;
    logic              hold_full;
    logic [CHAR_W-1:0] hold_data;
    logic              tx_take;
    logic              tx_idle;
    logic              rx_idle;
    logic              rx_done;
    logic [CHAR_W-1:0] rx_byte;
    logic              rx_valid;
    logic [CHAR_W-1:0] rx_buf;
    frame_ctx_t        tx_ctx;
    frame_ctx_t        rx_ctx;

    assign doze_pend = doze_req && doze_en;
    assign clk_en    = !stop_req && !doze_halt;
    assign quiescent = stop_req || doze_halt;
    assign tx_take   = clk_en && tx_idle && hold_full && !doze_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            doze_halt <= 1'b0;
        end else begin
            doze_halt <= doze_pend && (doze_halt || (tx_idle && rx_idle));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            doze_en   <= 1'b0;
            div_q     <= DIV_INIT;
            hold_full <= 1'b0;
            hold_data <= '0;
            rx_valid  <= 1'b0;
            rx_buf    <= '0;
        end else begin
            if (tx_take) begin
                hold_full <= 1'b0;
            end
            if (!stop_req) begin
                if (rd_en && rd_addr == ADDR_DATA) begin
                    rx_valid <= 1'b0;
                end
                if (wr_en) begin
                    case (wr_addr)
                        ADDR_DATA: begin
                            if (!hold_full) begin
                                hold_full <= 1'b1;
                                hold_data <= wr_data[CHAR_W-1:0];
                            end
                        end
                        ADDR_DIV:  div_q   <= wr_data;
                        ADDR_CTRL: doze_en <= wr_data[0];
                        default: ;
                    endcase
                end
            end
            if (rx_done) begin
                rx_valid <= 1'b1;
                rx_buf   <= rx_byte;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_DATA: rd_data = REG_W'(rx_buf);
            ADDR_DIV:  rd_data = div_q;
            ADDR_CTRL: rd_data = REG_W'(doze_en);
            default:   rd_data = REG_W'(pack_status(!tx_idle || hold_full, rx_valid, quiescent));
        endcase
    end

    uart_lp_baud #(.DIV_W(REG_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .en   (clk_en),
        .div  (div_q),
        .tick (tick)
    );

    uart_lp_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .en        (clk_en),
        .tick      (tick),
        .load      (tx_take),
        .load_data (hold_data),
        .txd       (txd),
        .idle      (tx_idle),
        .ctx_o     (tx_ctx)
    );

    uart_lp_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .en          (clk_en),
        .tick        (tick),
        .allow_start (!doze_pend),
        .rxd         (rxd),
        .done        (rx_done),
        .byte_o      (rx_byte),
        .idle        (rx_idle),
        .ctx_o       (rx_ctx)
    );
endmodule

// File: rtl/uart_lp_chk.sv
module uart_lp_chk
    import uart_lp_pkg::*;
#(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             stop_req,
    input logic             doze_req,
    input logic             doze_en,
    input logic             quiescent,
    input logic             txd,
    input logic             tx_idle,
    input logic             rx_idle,
    input frame_ctx_t       tx_ctx,
    input frame_ctx_t       rx_ctx,
    input logic [REG_W-1:0] div_q,
    input logic             hold_full,
    input logic             rx_valid
);
    assert_stop_freezes_tx_R8: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> $stable(tx_ctx) && $stable(txd));

    assert_stop_freezes_rx_R8: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> $stable(rx_ctx));

    assert_stop_holds_regs_R8: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> $stable(div_q) && $stable(hold_full) && $stable(rx_valid) && $stable(doze_en));

    assert_doze_halt_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (quiescent && !stop_req) |-> (tx_idle && rx_idle && txd));

    assert_doze_enters_halt_R5: assert property (@(posedge clk) disable iff (rst)
        (doze_req && doze_en && tx_idle && rx_idle) |=> quiescent);

    assert_doze_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        !doze_en |=> (quiescent == stop_req));

    assert_quiet_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        quiescent |=> $stable(tx_ctx) && $stable(rx_ctx) && $stable(txd));
endmodule

bind uart_lp uart_lp_chk #(.REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stop_req  (stop_req),
    .doze_req  (doze_req),
    .doze_en   (doze_en),
    .quiescent (quiescent),
    .txd       (txd),
    .tx_idle   (tx_idle),
    .rx_idle   (rx_idle),
    .tx_ctx    (tx_ctx),
    .rx_ctx    (rx_ctx),
    .div_q     (div_q),
    .hold_full (hold_full),
    .rx_valid  (rx_valid)
);

// File: tb/uart_lp_bench.sv
module uart_lp_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       rd_en;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic       rxd;
    logic       txd;
    logic       doze_req;
    logic       stop_req;
    logic       quiescent;
    logic       loop;
    logic       bench_rx;

    int         n_cmp = 0;
    int         n_bad = 0;
    int         cur_div = 3;
    logic [8:0] got_q[$];

    always #5 clk = ~clk;
    assign rxd = loop ? txd : bench_rx;

    uart_lp u_uart_lp (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rxd       (rxd),
        .txd       (txd),
        .doze_req  (doze_req),
        .stop_req  (stop_req),
        .quiescent (quiescent)
    );

    function automatic int bit_len(input int div);
        return 16 * (div + 1);
    endfunction

    function automatic logic [7:0] exp_stat(input logic busy, input logic valid, input logic q);
        return {5'b0, q, valid, busy};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_wait(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (!stop_req) k++;
        end
    endtask

    // line monitor: decodes txd, counting only cycles not frozen by stop
    initial begin
        logic       prev;
        logic [7:0] sh;
        logic       err;
        int         p;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst !== 1'b0) begin
                prev = 1'b1;
            end else begin
                if (prev && !txd && !stop_req) begin
                    p   = bit_len(cur_div);
                    err = 1'b0;
                    run_wait(p / 2);
                    if (txd !== 1'b0) err = 1'b1;
                    for (int i = 0; i < 8; i++) begin
                        run_wait(p);
                        sh[i] = txd;
                    end
                    run_wait(p);
                    if (txd !== 1'b1) err = 1'b1;
                    got_q.push_back({err, sh});
                end
                prev = txd;
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, input logic clr, output logic [7:0] v);
        @(posedge clk); #1;
        rd_addr = a; rd_en = clr;
        @(negedge clk);
        v = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic wait_frame(output logic [8:0] v);
        int t = 0;
        while (got_q.size() == 0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        if (got_q.size() != 0) v = got_q.pop_front();
        else v = 9'h1FF;
    endtask

    task automatic set_div(input int d);
        reg_write(2'd1, 8'(d));
        cur_div = d;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_bit);
        int p = bit_len(cur_div);
        @(posedge clk); #1;
        bench_rx = 1'b0;
        repeat (p) @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            #1 bench_rx = b[i];
            repeat (p) @(posedge clk);
        end
        #1 bench_rx = stop_bit;
        repeat (stop_bit ? p : (p * 5) / 8) @(posedge clk);
        #1 bench_rx = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [8:0] f;
        logic       tx0;
        int         bad;
        int         p;
        void'($urandom(32'd2024));
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_en = 1'b0; rd_addr = 2'd3; doze_req = 1'b0; stop_req = 1'b0;
        loop = 1'b1; bench_rx = 1'b1;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk("R1 txd", txd, 1);
        chk("R1 quiescent", quiescent, 0);
        reg_read(2'd3, 1'b0, v); chk("R1 status", v, 0);
        reg_read(2'd1, 1'b0, v); chk("R1 divisor", v, 3);
        reg_read(2'd2, 1'b0, v); chk("R1 control", v, 0);

        // R2/R3 random loopback frames
        for (int i = 0; i < 12; i++) begin
            logic [7:0] b;
            int d;
            d = $urandom_range(0, 3);
            if (d != cur_div) set_div(d);
            b = 8'($urandom_range(0, 255));
            reg_write(2'd0, b);
            wait_frame(f);
            chk("R2 tx frame", f, {1'b0, b});
            repeat (bit_len(cur_div)) @(posedge clk);
            reg_read(2'd3, 1'b0, v); chk("R3 valid set", v[1], 1);
            reg_read(2'd0, 1'b1, v); chk("R3 rx data", v, b);
            reg_read(2'd3, 1'b0, v); chk("R3 valid cleared", v, exp_stat(0, 0, 0));
        end

        // R3 directed receive patterns
        loop = 1'b0;
        set_div(1);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] b;
            b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'hA5;
            send_rx(b, 1'b1);
            repeat (bit_len(cur_div)) @(posedge clk);
            reg_read(2'd3, 1'b0, v); chk("R3 directed valid", v[1], 1);
            reg_read(2'd0, 1'b1, v); chk("R3 directed data", v, b);
        end
        send_rx(8'h3C, 1'b0);
        repeat (2 * bit_len(cur_div)) @(posedge clk);
        reg_read(2'd3, 1'b0, v); chk("R3 bad stop discarded", v[1], 0);

        // R4 one-entry holding register, third write dropped
        loop = 1'b1;
        set_div(0);
        reg_write(2'd0, 8'h11);
        reg_write(2'd0, 8'h22);
        reg_write(2'd0, 8'h33);
        reg_read(2'd3, 1'b0, v); chk("R4 busy", v[0], 1);
        wait_frame(f); chk("R4 first", f, 9'h011);
        wait_frame(f); chk("R4 second", f, 9'h022);
        repeat (400) @(posedge clk);
        chk("R4 dropped write absent", got_q.size(), 0);
        reg_read(2'd3, 1'b0, v); chk("R4 idle after", v[0], 0);
        reg_read(2'd0, 1'b1, v);

        // R5/R6/R10 doze with enable set
        set_div(1);
        p = bit_len(cur_div);
        reg_write(2'd2, 8'h01);
        reg_write(2'd0, 8'h6C);
        repeat (60) @(posedge clk);
        #1 doze_req = 1'b1;
        @(negedge clk); chk("R5 no halt mid-char", quiescent, 0);
        wait_frame(f); chk("R5 char completes", f, 9'h06C);
        repeat (2 * p) @(posedge clk);
        @(negedge clk); chk("R10 doze halted", quiescent, 1);
        reg_write(2'd0, 8'h93);
        bad = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (txd !== 1'b1 || quiescent !== 1'b1) bad++;
        end
        chk("R5 no new char while dozing", bad, 0);
        reg_read(2'd3, 1'b0, v); chk("R10 status in doze", v, exp_stat(1, 1, 1));
        @(posedge clk); #1 doze_req = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R6 quiescent released", quiescent, 0);
        reg_read(2'd0, 1'b1, v); chk("R6 rx kept across doze", v, 8'h6C);
        wait_frame(f); chk("R6 held byte sent", f, 9'h093);
        repeat (p) @(posedge clk);
        reg_read(2'd0, 1'b1, v); chk("R6 rx after doze", v, 8'h93);

        // R7 doze request with enable clear
        reg_write(2'd2, 8'h00);
        @(posedge clk); #1 doze_req = 1'b1;
        reg_write(2'd0, 8'h4E);
        wait_frame(f); chk("R7 frame flows", f, 9'h04E);
        @(negedge clk); chk("R7 quiescent low", quiescent, 0);
        @(posedge clk); #1 doze_req = 1'b0;
        repeat (p) @(posedge clk);
        reg_read(2'd0, 1'b1, v); chk("R7 rx data", v, 8'h4E);

        // R8/R9 stop mid-character
        set_div(2);
        p = bit_len(cur_div);
        reg_write(2'd0, 8'hB7);
        repeat (4 * p) @(posedge clk);
        #1 stop_req = 1'b1;
        @(negedge clk);
        tx0 = txd;
        chk("R10 stop quiescent", quiescent, 1);
        reg_write(2'd1, 8'h00);
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== tx0) bad++;
        end
        chk("R8 txd frozen", bad, 0);
        reg_read(2'd1, 1'b0, v); chk("R8 write ignored in stop", v, 2);
        reg_read(2'd3, 1'b0, v); chk("R8 status frozen", v, exp_stat(1, 0, 1));
        @(posedge clk); #1 stop_req = 1'b0;
        wait_frame(f); chk("R9 tx resumes intact", f, 9'h0B7);
        repeat (p) @(posedge clk);
        reg_read(2'd3, 1'b0, v); chk("R9 rx valid after stop", v, exp_stat(0, 1, 0));
        reg_read(2'd0, 1'b1, v); chk("R9 rx resumes intact", v, 8'hB7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule